// File: doc/BRIEF.md
# Flash Completion Status Poller

This block runs on the host side of a parallel NOR-style flash. A program or erase command has already been issued to the flash. The block then reads the device over and over to find out when the internal operation has finished. The flash has no ready/busy pin for this purpose. Completion is inferred from how certain data bits behave across successive reads.

Two detection methods are available, chosen per request:

- **Data polling** compares bit 7 of each status read with a target value.
- **Toggle detection** watches whether bit 6 stops changing between consecutive reads.

Each status read is a plain read cycle with fixed strobe timing. Once completion is seen, the block performs one more read to fetch valid array data. It then reports one of three results to the requester: success, verify error or timeout.

A requester starts a job with a one-cycle `startReq`. The request carries:

- the method and operation kind,
- the byte that was written (program only),
- the address to read,
- a ceiling on status reads.

The requester then waits for the one-cycle `doneValid` pulse.

Top module: `flash_status_poller`

## Requirements
- R1: While reset is held and after it is released with no request, `busy` and `doneValid` are 0, and `flashCeN`, `flashOeN` and `flashWeN` are all 1.
- R2: Every read drives `flashCeN` and `flashOeN` low together for exactly RD_CYC cycles, with `flashWeN` high and `flashAddr` equal to the `pollAddr` latched at start. Consecutive reads are separated by at least one cycle with both strobes high. No read happens while idle.
- R3: With `modeSel`=0 and `opErase`=0, a status read completes the wait when its bit 7 equals bit 7 of `expByte`.
- R4: With `modeSel`=0 and `opErase`=1, a status read completes the wait when its bit 7 is 1.
- R5: With `modeSel`=1, the wait completes on the first status read whose bit 6 equals bit 6 of the status read just before it. The first status read of a job can never complete the wait.
- R6: After completion, exactly one further read is made. `readData` returns that byte when `doneValid` pulses. The total number of reads is the completing read's index plus one.
- R7: For a program job (`opErase`=0), `resultCode` is 1 (verify error) when the final byte differs from `expByte`, and 0 (ok) when it matches. For an erase job, `resultCode` is 0 on completion.
- R8: If none of the first `maxPolls` status reads completes the wait, `resultCode` is 2 (timeout). In that case no final read is made and `readData` holds the last status byte. A `maxPolls` of 0 behaves as 1.
- R9: When the completing status read is also the last one `maxPolls` allows, completion wins and no timeout is reported.
- R10: `startReq` is ignored while `busy` is 1, as are changes to the request inputs. `doneValid` lasts one cycle, and `busy` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle job request, taken only when idle |
| modeSel | input | 1 | 0 = bit-7 data polling, 1 = bit-6 toggle detection |
| opErase | input | 1 | 1 = erase job, 0 = program job |
| expByte | input | 8 | Byte that was programmed |
| pollAddr | input | ADDR_W | Address read during the job |
| maxPolls | input | CNT_W | Maximum number of status reads |
| flashAddr | output | ADDR_W | Address to the flash |
| flashCeN | output | 1 | Active-low chip enable |
| flashOeN | output | 1 | Active-low output enable |
| flashWeN | output | 1 | Active-low write enable, held high |
| flashDq | input | 8 | Data byte returned by the flash |
| busy | output | 1 | Job in progress |
| doneValid | output | 1 | One-cycle result strobe |
| resultCode | output | 2 | 0 ok, 1 verify error, 2 timeout |
| readData | output | 8 | Final array byte, or last status byte on timeout |

## Verification
Completion detection and the poll ceiling can both be met by the same status read. That happens when the flash becomes ready exactly at read `maxPolls`.

The bench provokes this by sweeping the number of busy reads in its flash model against a range of ceilings, including 0 and 1. Every pairing where the completing read equals the ceiling therefore occurs for both methods. Such cases are judged as R9: the result must be ok or verify error, never timeout, and exactly one extra read must follow.

A second overlap is a fresh `startReq` arriving mid-job. It must leave the result and the read count untouched.

// File: rtl/poll_pkg.sv
package poll_pkg;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_VERIFY  = 2'd1,
    RES_TIMEOUT = 2'd2
  } pollRes_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic rdActive;
    logic sampleStatus;
    logic sampleFinal;
  } dpCtl_t;

  // flags from datapath to control
  typedef struct packed {
    logic strobeLast;
    logic statusDone;
    logic countHit;
    logic verifyOk;
  } dpStat_t;

endpackage

// File: rtl/poll_dpath.sv
module poll_dpath
  import poll_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int RD_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  output dpStat_t           stat,
  input  logic              modeSel,
  input  logic              opErase,
  input  logic [7:0]        expByte,
  input  logic [ADDR_W-1:0] pollAddr,
  input  logic [CNT_W-1:0]  maxPolls,
  input  logic [7:0]        flashDq,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        readData
);

  localparam int STR_W = (RD_CYC > 1) ? $clog2(RD_CYC) : 1;

  logic              modeR, eraseR;
  logic [7:0]        expR;
  logic [ADDR_W-1:0] addrR;
  logic [CNT_W-1:0]  maxR;
  logic [CNT_W-1:0]  pollCnt;
  logic [7:0]        lastByte;
  logic              prevBit6, haveOne, prevValid;
  logic              dataDone, toggleDone;

  // strobe width counter; variant picked by RD_CYC
  generate
    if (RD_CYC == 1) begin : g_single
      assign stat.strobeLast = ctl.rdActive;
    end else begin : g_multi
      logic [STR_W-1:0] strCnt;
      always_ff @(posedge clk) begin
        if (!rstN || !ctl.rdActive || strCnt == STR_W'(RD_CYC - 1))
          strCnt <= '0;
        else
          strCnt <= strCnt + 1'b1;
      end
      assign stat.strobeLast = ctl.rdActive && (strCnt == STR_W'(RD_CYC - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeR     <= 1'b0;
      eraseR    <= 1'b0;
      expR      <= '0;
      addrR     <= '0;
      maxR      <= '0;
      pollCnt   <= '0;
      lastByte  <= '0;
      prevBit6  <= 1'b0;
      haveOne   <= 1'b0;
      prevValid <= 1'b0;
    end else if (ctl.loadCfg) begin
      modeR     <= modeSel;
      eraseR    <= opErase;
      expR      <= expByte;
      addrR     <= pollAddr;
      maxR      <= maxPolls;
      pollCnt   <= '0;
      haveOne   <= 1'b0;
      prevValid <= 1'b0;
    end else if (ctl.sampleStatus) begin
      lastByte  <= flashDq;
      prevBit6  <= lastByte[6];
      prevValid <= haveOne;
      haveOne   <= 1'b1;
      pollCnt   <= pollCnt + 1'b1;
    end else if (ctl.sampleFinal) begin
      lastByte  <= flashDq;
    end
  end

  always_comb begin
    dataDone   = eraseR ? lastByte[7] : (lastByte[7] == expR[7]);
    toggleDone = prevValid && (lastByte[6] == prevBit6);
  end

  assign stat.statusDone = modeR ? toggleDone : dataDone;
  assign stat.countHit   = (pollCnt >= maxR);
  assign stat.verifyOk   = eraseR || (flashDq == expR);
  assign flashAddr       = addrR;
  assign readData        = lastByte;

endmodule

// File: rtl/poll_ctrl.sv
module poll_ctrl
  import poll_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  dpStat_t    stat,
  output dpCtl_t     ctl,
  output logic       busy,
  output logic       doneValid,
  output logic [1:0] resultCode
);

  typedef enum logic [2:0] {
    S_IDLE, S_STAT, S_EVAL, S_FINAL, S_REPORT
  } pollState_e;

  pollState_e state, stateNxt;
  pollRes_e   resR, resNxt;

  always_comb begin
    ctl.loadCfg      = (state == S_IDLE) && startReq;
    ctl.rdActive     = (state == S_STAT) || (state == S_FINAL);
    ctl.sampleStatus = (state == S_STAT) && stat.strobeLast;
    ctl.sampleFinal  = (state == S_FINAL) && stat.strobeLast;
  end

  always_comb begin
    stateNxt = state;
    resNxt   = resR;
    unique case (state)
      S_IDLE:   if (startReq) stateNxt = S_STAT;
      S_STAT:   if (stat.strobeLast) stateNxt = S_EVAL;
      S_EVAL: begin
        if (stat.statusDone) begin
          stateNxt = S_FINAL;
        end else if (stat.countHit) begin
          stateNxt = S_REPORT;
          resNxt   = RES_TIMEOUT;
        end else begin
          stateNxt = S_STAT;
        end
      end
      S_FINAL: begin
        if (stat.strobeLast) begin
          stateNxt = S_REPORT;
          resNxt   = stat.verifyOk ? RES_OK : RES_VERIFY;
        end
      end
      S_REPORT: stateNxt = S_IDLE;
      default:  stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      resR  <= RES_OK;
    end else begin
      state <= stateNxt;
      resR  <= resNxt;
    end
  end

  assign busy       = (state != S_IDLE);
  assign doneValid  = (state == S_REPORT);
  assign resultCode = resR;

endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
  import poll_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int RD_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              modeSel,
  input  logic              opErase,
  input  logic [7:0]        expByte,
  input  logic [ADDR_W-1:0] pollAddr,
  input  logic [CNT_W-1:0]  maxPolls,
  output logic [ADDR_W-1:0] flashAddr,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic              flashWeN,
  input  logic [7:0]        flashDq,
  output logic              busy,
  output logic              doneValid,
  output logic [1:0]        resultCode,
  output logic [7:0]        readData
);

  dpCtl_t  ctl;
  dpStat_t stat;

  poll_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .stat       (stat),
    .ctl        (ctl),
    .busy       (busy),
    .doneValid  (doneValid),
    .resultCode (resultCode)
  );

  poll_dpath #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .stat      (stat),
    .modeSel   (modeSel),
    .opErase   (opErase),
    .expByte   (expByte),
    .pollAddr  (pollAddr),
    .maxPolls  (maxPolls),
    .flashDq   (flashDq),
    .flashAddr (flashAddr),
    .readData  (readData)
  );

  assign flashCeN = !ctl.rdActive;
  assign flashOeN = !ctl.rdActive;
  assign flashWeN = 1'b1;

endmodule

// File: rtl/poll_checker.sv
module poll_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              busy,
  input logic              doneValid,
  input logic [1:0]        resultCode,
  input logic              flashOeN,
  input logic              flashCeN,
  input logic [ADDR_W-1:0] flashAddr
);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && !busy));

  assert_start_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (flashOeN && flashCeN));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(flashAddr));

  assert_code_legal_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (resultCode != 2'd3));

endmodule

bind flash_status_poller poll_checker #(.ADDR_W(ADDR_W)) u_pollChk (
  .clk        (clk),
  .rstN       (rstN),
  .startReq   (startReq),
  .busy       (busy),
  .doneValid  (doneValid),
  .resultCode (resultCode),
  .flashOeN   (flashOeN),
  .flashCeN   (flashCeN),
  .flashAddr  (flashAddr)
);

// File: tb/flash_status_poller_bench.sv
module flash_status_poller_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam int RD_CYC = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startReq = 1'b0;
  logic              modeSel = 1'b0;
  logic              opErase = 1'b0;
  logic [7:0]        expByte = '0;
  logic [ADDR_W-1:0] pollAddr = '0;
  logic [CNT_W-1:0]  maxPolls = '0;
  logic [ADDR_W-1:0] flashAddr;
  logic              flashCeN, flashOeN, flashWeN;
  logic [7:0]        flashDq;
  logic              busy, doneValid;
  logic [1:0]        resultCode;
  logic [7:0]        readData;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // flash model configuration
  int                readIdx = 0;
  int                readBase = 0;
  int                relIdx;
  int                cfgN = 0;
  logic              cfgErase = 1'b0;
  logic [7:0]        cfgExp = '0;
  logic [7:0]        cfgArr = '0;
  logic [ADDR_W-1:0] cfgAddr = '0;
  int                lowCnt = 0;
  logic              strobeBad = 1'b0;
  logic              monOn = 1'b0;

  flash_status_poller #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC)
  ) u_flash_status_poller (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .modeSel    (modeSel),
    .opErase    (opErase),
    .expByte    (expByte),
    .pollAddr   (pollAddr),
    .maxPolls   (maxPolls),
    .flashAddr  (flashAddr),
    .flashCeN   (flashCeN),
    .flashOeN   (flashOeN),
    .flashWeN   (flashWeN),
    .flashDq    (flashDq),
    .busy       (busy),
    .doneValid  (doneValid),
    .resultCode (resultCode),
    .readData   (readData)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // model: first cfgN reads busy (bit6 alternates from 0), then array byte
  always @(posedge flashOeN) readIdx <= readIdx + 1;

  always_comb begin
    relIdx = readIdx - readBase;
    if (relIdx < cfgN)
      flashDq = {cfgErase ? 1'b0 : ~cfgExp[7], relIdx[0], 6'h15};
    else
      flashDq = cfgArr;
  end

  // strobe monitor (R2)
  always @(negedge clk) begin
    if (monOn) begin
      if (flashWeN !== 1'b1 || flashCeN !== flashOeN) strobeBad = 1'b1;
      if (!flashOeN) begin
        lowCnt = lowCnt + 1;
        if (flashAddr !== cfgAddr) strobeBad = 1'b1;
      end else begin
        if (lowCnt != 0 && lowCnt != RD_CYC) strobeBad = 1'b1;
        lowCnt = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] modelByte(input int i, input int n, input bit er,
                                           input logic [7:0] ex, input logic [7:0] ar);
    logic [7:0] b;
    if (i <= n) b = {er ? 1'b0 : ~ex[7], 1'(i - 1), 6'h15};
    else        b = ar;
    return b;
  endfunction

  task automatic runCase(input bit md, input bit er, input bit flip, input int n, input int mx);
    logic [7:0] ex, ar, b;
    int limit, detect, expReads, expCode, expData, waitCnt, reads;
    string tag;
    bit ok;
    ex = 8'((n * 53) + (mx * 29) + (md * 7) + (er * 3) + flip + tests);
    ar = er ? 8'hFF : (flip ? (ex ^ 8'h01) : ex);
    limit = (mx == 0) ? 1 : mx;
    detect = 0;
    for (int i = 1; i <= limit; i++) begin
      if (detect == 0) begin
        b = modelByte(i, n, er, ex, ar);
        if (!md) ok = er ? b[7] : (b[7] == ex[7]);
        else     ok = (i >= 2) && (b[6] == modelByte(i - 1, n, er, ex, ar)[6]);
        if (ok) detect = i;
      end
    end
    if (detect != 0) begin
      expCode  = (!er && ar != ex) ? 1 : 0;
      expData  = ar;
      expReads = detect + 1;
      if (detect == limit) tag = "R9";
      else if (md)         tag = "R5";
      else if (er)         tag = "R4";
      else                 tag = "R3";
    end else begin
      expCode  = 2;
      expData  = modelByte(limit, n, er, ex, ar);
      expReads = limit;
      tag      = "R8";
    end

    @(negedge clk);
    cfgN = n; cfgErase = er; cfgExp = ex; cfgArr = ar;
    cfgAddr = ADDR_W'(16'h1000 + n * 17 + mx);
    readBase = readIdx;
    strobeBad = 1'b0; lowCnt = 0; monOn = 1'b1;
    modeSel = md; opErase = er; expByte = ex; pollAddr = cfgAddr;
    maxPolls = CNT_W'(mx); startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    modeSel = ~md; opErase = ~er; expByte = ~ex; pollAddr = ~cfgAddr; maxPolls = '1;
    @(negedge clk);
    startReq = 1'b1;   // ignored while busy (R10)
    @(negedge clk);
    startReq = 1'b0;
    waitCnt = 0;
    while (!doneValid && waitCnt < 2000) begin
      @(negedge clk);
      waitCnt++;
    end
    if (!doneValid) begin
      check(1'b0, "R6 done never seen", 0, 1);
    end else begin
      reads = readIdx - readBase;
      check(resultCode == 2'(expCode), flip ? "R7 result" : {tag, " result"},
            int'(resultCode), expCode);
      check(readData == 8'(expData), (expCode == 2) ? "R8 data" : "R6 data",
            int'(readData), expData);
      check(reads == expReads, (expCode == 2) ? "R8 read count" : "R6 read count",
            reads, expReads);
    end
    @(negedge clk);
    check(!busy && !doneValid, "R10 one-cycle done", int'(busy), 0);
    @(negedge clk);
    @(negedge clk);
    check(!strobeBad && !busy, "R2 strobes", int'(strobeBad), 0);
    monOn = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int mxList[6];
    mxList = '{0, 1, 2, 3, 4, 7};
    repeat (3) @(negedge clk);
    check(!busy && !doneValid && flashCeN && flashOeN && flashWeN,
          "R1 in reset", int'(busy), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !doneValid && flashCeN && flashOeN && flashWeN,
          "R1 after reset", int'(flashOeN), 1);
    for (int md = 0; md < 2; md++)
      for (int er = 0; er < 2; er++)
        for (int fl = 0; fl < 2; fl++)
          if (!(er == 1 && fl == 1))
            for (int n = 0; n < 6; n++)
              for (int k = 0; k < 6; k++)
                runCase(md[0], er[0], fl[0], n, mxList[k]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule